// File: doc/BRIEF.md
# Offset programming port for a synchronous FIFO

This block keeps the two programmable watermark values of a synchronous FIFO, one for the near-empty flag and one for the near-full flag, and provides the control port through which they are loaded and read. An active-low configuration select is decoded together with the active-low write, read and shift requests. While the select is low, the port either writes the offsets a slice at a time from the input bus, reads them back a slice at a time onto the output bus, or shifts them in one bit per clock. While the select is high, the write and read requests pass through as ordinary memory access strobes for the FIFO core.

The bus may be narrower than an offset. In that case each offset is split into a low slice and a high slice, and the port steps through a fixed order of four slices. When the bus is at least as wide as an offset, the order has two steps. The choice between parallel and serial loading is latched at reset and stays fixed until the next reset. Read-back is allowed in both methods.

Top module: `fifo_ofs_port`

## Requirements
- R1: While `rst` is high, at each clock the near-empty offset takes `DEF_EMPTY` and the near-full offset takes `DEF_FULL`. Both slice pointers return to the first slice, `bus_o`, `bus_vld_o`, `mem_wr_o` and `mem_rd_o` clear, and `mode_serial_i` is latched (1 = serial, 0 = parallel).
- R2: In parallel mode, a clock with `cfg_n_i`=0, `wr_n_i`=0, `rd_n_i`=1 and `shift_n_i`=1 stores `bus_i` into the slice named by the write pointer. The pointer then advances by one slice.
- R3: With `BUS_W` < `OFS_W`, the slice order is: empty-offset low (bits BUS_W-1:0), empty-offset high, full-offset low, full-offset high. A high slice takes `bus_i[OFS_W-BUS_W-1:0]`. With `BUS_W` >= `OFS_W`, the order is the empty offset, then the full offset.
- R4: After the last slice, the write pointer wraps back to the first slice.
- R5: In either mode, a clock with `cfg_n_i`=0, `rd_n_i`=0, `wr_n_i`=1 and `shift_n_i`=1 places the slice named by the read pointer on `bus_o` (high slices zero-extended) and raises `bus_vld_o`, both one clock later. The read pointer then advances by one slice, and `bus_o` holds its value otherwise.
- R6: The read pointer is independent of the write pointer and wraps after the last slice.
- R7: In serial mode, a clock with `cfg_n_i`=0, `shift_n_i`=0, `wr_n_i`=1 and `rd_n_i`=1 shifts `ser_di_i` into the top of the concatenation {full, empty}. After 2*OFS_W shifts, the first bit sits in the empty-offset LSB and the last bit in the full-offset MSB.
- R8: The method is fixed at reset. Parallel writes do nothing in serial mode, shifts do nothing in parallel mode, and `mode_serial_i` is ignored outside reset.
- R9: With `cfg_n_i`=1, `mem_wr_o` follows `!wr_n_i` and `mem_rd_o` follows `!rd_n_i`, one clock later, and the offsets are untouched. With both requests high, neither strobe is raised.
- R10: Any other combination with `cfg_n_i`=0 is a no-op: offsets, pointers and `bus_o` stay unchanged, and no strobe or `bus_vld_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_serial_i | input | 1 | Method select sampled at reset (1 serial) |
| cfg_n_i | input | 1 | Configuration select, active low |
| wr_n_i | input | 1 | Write request, active low |
| rd_n_i | input | 1 | Read request, active low |
| shift_n_i | input | 1 | Serial shift request, active low |
| ser_di_i | input | 1 | Serial data bit |
| bus_i | input | BUS_W | Parallel slice input |
| bus_o | output | BUS_W | Read-back slice |
| bus_vld_o | output | 1 | Read-back slice valid |
| empty_ofs_o | output | OFS_W | Near-empty offset |
| full_ofs_o | output | OFS_W | Near-full offset |
| mem_wr_o | output | 1 | Memory write strobe to FIFO core |
| mem_rd_o | output | 1 | Memory read strobe to FIFO core |

## Verification
The bench writes a fifth slice to prove the write pointer wraps. A design that failed to wrap would clobber nothing, or would write a non-existent slice, and the empty-offset low byte would stay stale. Reads are interleaved with writes so that the two pointers sit at different slices. A shared pointer would return the wrong slice. The method input is toggled after reset, and parallel writes are attempted in serial mode and shifts in parallel mode. A design that sampled the method continuously, or failed to gate by method, would corrupt the offsets. A full 24-bit serial load checks the bit order: a reversed shift would swap the LSB and MSB ends of both offsets.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PWR  = 2'd1,
    OP_PRD  = 2'd2,
    OP_SHF  = 2'd3
  } ofs_op_e;
endpackage

// File: rtl/ofs_decode.sv
module ofs_decode
  import ofs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfg_n,
  input  logic    wr_n,
  input  logic    rd_n,
  input  logic    shift_n,
  output ofs_op_e op,
  output logic    mem_wr,
  output logic    mem_rd
);
  always_comb begin
    op = OP_IDLE;
    if (!cfg_n) begin
      case ({wr_n, rd_n, shift_n})
        3'b011:  op = OP_PWR;
        3'b101:  op = OP_PRD;
        3'b110:  op = OP_SHF;
        default: op = OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr <= 1'b0;
      mem_rd <= 1'b0;
    end else begin
      mem_wr <= cfg_n & ~wr_n;
      mem_rd <= cfg_n & ~rd_n;
    end
  end

  // R10
  cfg_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_n) |=> (!mem_wr && !mem_rd));
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int BUS_W = 8,
  parameter logic [OFS_W-1:0] DEF_EMPTY = '0,
  parameter logic [OFS_W-1:0] DEF_FULL  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  ofs_op_e          op,
  input  logic [BUS_W-1:0] din,
  input  logic             ser_di,
  output logic [OFS_W-1:0] empty_q,
  output logic [OFS_W-1:0] full_q
);
  localparam int N_PART = (BUS_W >= OFS_W) ? 2 : 4;
  localparam int PAIR_W = 2 * OFS_W;

  logic [PAIR_W-1:0] pair, pair_wr;
  logic [1:0]        wptr;
  logic              ser_mode;

  assign empty_q = pair[OFS_W-1:0];
  assign full_q  = pair[PAIR_W-1:OFS_W];

  generate
    if (N_PART == 2) begin : g_wide
      always_comb begin
        if (wptr[0]) pair_wr = {din[OFS_W-1:0], pair[OFS_W-1:0]};
        else         pair_wr = {pair[PAIR_W-1:OFS_W], din[OFS_W-1:0]};
      end
    end else begin : g_narrow
      localparam int HI_W = OFS_W - BUS_W;
      logic [OFS_W-1:0] tgt, upd;
      always_comb begin
        tgt = wptr[1] ? full_q : empty_q;
        if (wptr[0]) upd = {din[HI_W-1:0], tgt[BUS_W-1:0]};
        else         upd = {tgt[OFS_W-1:BUS_W], din};
        pair_wr = wptr[1] ? {upd, empty_q} : {full_q, upd};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pair     <= {DEF_FULL, DEF_EMPTY};
      wptr     <= 2'd0;
      ser_mode <= mode_i;
    end else begin
      case (op)
        OP_PWR: if (!ser_mode) begin
          pair <= pair_wr;
          wptr <= (wptr == 2'(N_PART - 1)) ? 2'd0 : wptr + 2'd1;
        end
        OP_SHF: if (ser_mode) pair <= {ser_di, pair[PAIR_W-1:1]};
        default: ;
      endcase
    end
  end

  // R1
  reset_default_chk: assert property (@(posedge clk)
    rst |=> (empty_q == DEF_EMPTY && full_q == DEF_FULL && wptr == 2'd0));
  // R8
  pwr_in_serial_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PWR && ser_mode) |=> ($stable(empty_q) && $stable(full_q)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE || op == OP_PRD) |=> ($stable(pair) && $stable(wptr)));
  // R4
  wptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PWR && !ser_mode && wptr == 2'(N_PART - 1)) |=> (wptr == 2'd0));
  // R7
  shift_top_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHF && ser_mode) |=> (full_q[OFS_W-1] == $past(ser_di)));
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ofs_op_e          op,
  input  logic [OFS_W-1:0] empty_q,
  input  logic [OFS_W-1:0] full_q,
  output logic [BUS_W-1:0] dout,
  output logic             dout_vld
);
  localparam int N_PART = (BUS_W >= OFS_W) ? 2 : 4;

  logic [1:0]       rptr;
  logic [OFS_W-1:0] src;
  logic [BUS_W-1:0] part;

  generate
    if (N_PART == 2) begin : g_wide
      always_comb begin
        src  = rptr[0] ? full_q : empty_q;
        part = BUS_W'(src);
      end
    end else begin : g_narrow
      always_comb begin
        src  = rptr[1] ? full_q : empty_q;
        part = rptr[0] ? BUS_W'(src >> BUS_W) : src[BUS_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= 2'd0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= (op == OP_PRD);
      if (op == OP_PRD) begin
        dout <= part;
        rptr <= (rptr == 2'(N_PART - 1)) ? 2'd0 : rptr + 2'd1;
      end
    end
  end

  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PRD) |=> dout_vld);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_PRD) |=> (!dout_vld && $stable(dout) && $stable(rptr)));
endmodule

// File: rtl/fifo_ofs_port.sv
module fifo_ofs_port
  import ofs_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int BUS_W = 8,
  parameter logic [OFS_W-1:0] DEF_EMPTY = OFS_W'(127),
  parameter logic [OFS_W-1:0] DEF_FULL  = OFS_W'(127)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_serial_i,
  input  logic             cfg_n_i,
  input  logic             wr_n_i,
  input  logic             rd_n_i,
  input  logic             shift_n_i,
  input  logic             ser_di_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_vld_o,
  output logic [OFS_W-1:0] empty_ofs_o,
  output logic [OFS_W-1:0] full_ofs_o,
  output logic             mem_wr_o,
  output logic             mem_rd_o
);
  ofs_op_e op;

  ofs_decode u_dec (
    .clk(clk), .rst(rst), .cfg_n(cfg_n_i), .wr_n(wr_n_i), .rd_n(rd_n_i),
    .shift_n(shift_n_i), .op(op), .mem_wr(mem_wr_o), .mem_rd(mem_rd_o)
  );

  ofs_store #(.OFS_W(OFS_W), .BUS_W(BUS_W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)) u_store (
    .clk(clk), .rst(rst), .mode_i(mode_serial_i), .op(op), .din(bus_i),
    .ser_di(ser_di_i), .empty_q(empty_ofs_o), .full_q(full_ofs_o)
  );

  ofs_readback #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_rb (
    .clk(clk), .rst(rst), .op(op), .empty_q(empty_ofs_o), .full_q(full_ofs_o),
    .dout(bus_o), .dout_vld(bus_vld_o)
  );

  // R9
  mem_wr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> $past(cfg_n_i && !wr_n_i));
  // R9
  mem_rd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_n_i && !rd_n_i) |=> mem_rd_o);
  // R9
  mem_offsets_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_n_i |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));
endmodule

// File: tb/tb_fifo_ofs_port.sv
module tb_fifo_ofs_port;
  logic clk = 1'b0;
  logic rst = 1'b1, mode = 1'b0;
  logic cfg_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, shift_n = 1'b1, sdi = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic vld, mw, mr;
  logic [11:0] e_o, f_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fifo_ofs_port #(.OFS_W(12), .BUS_W(8), .DEF_EMPTY(12'h07F), .DEF_FULL(12'h0FF)) dut (
    .clk(clk), .rst(rst), .mode_serial_i(mode), .cfg_n_i(cfg_n), .wr_n_i(wr_n),
    .rd_n_i(rd_n), .shift_n_i(shift_n), .ser_di_i(sdi), .bus_i(din), .bus_o(dout),
    .bus_vld_o(vld), .empty_ofs_o(e_o), .full_ofs_o(f_o), .mem_wr_o(mw), .mem_rd_o(mr)
  );

  // behavioural reference model
  logic [11:0] m_e, m_f;
  logic [7:0]  m_dout;
  bit m_vld, m_mw, m_mr, m_ser;
  int wp, rp;

  always @(posedge clk) begin
    if (rst) begin
      m_e = 12'h07F; m_f = 12'h0FF; m_dout = '0; m_vld = 0; m_mw = 0; m_mr = 0;
      wp = 0; rp = 0; m_ser = mode;
    end else begin
      m_mw = cfg_n && !wr_n;
      m_mr = cfg_n && !rd_n;
      m_vld = 0;
      if (!cfg_n) begin
        if (!wr_n && rd_n && shift_n) begin
          if (!m_ser) begin
            case (wp)
              0: m_e[7:0]  = din;
              1: m_e[11:8] = din[3:0];
              2: m_f[7:0]  = din;
              default: m_f[11:8] = din[3:0];
            endcase
            wp = (wp + 1) % 4;
          end
        end else if (wr_n && !rd_n && shift_n) begin
          case (rp)
            0: m_dout = m_e[7:0];
            1: m_dout = {4'h0, m_e[11:8]};
            2: m_dout = m_f[7:0];
            default: m_dout = {4'h0, m_f[11:8]};
          endcase
          rp = (rp + 1) % 4;
          m_vld = 1;
        end else if (wr_n && rd_n && !shift_n && m_ser) begin
          logic [23:0] t;
          t = {m_f, m_e};
          t = {sdi, t[23:1]};
          m_f = t[23:12];
          m_e = t[11:0];
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk(tag, "empty", 32'(e_o), 32'(m_e));
    chk(tag, "full", 32'(f_o), 32'(m_f));
    chk(tag, "dout", 32'(dout), 32'(m_dout));
    chk(tag, "vld", 32'(vld), 32'(m_vld));
    chk(tag, "mem_wr", 32'(mw), 32'(m_mw));
    chk(tag, "mem_rd", 32'(mr), 32'(m_mr));
  endtask

  task automatic step(string tag, bit c, bit w, bit r, bit s, bit b, logic [7:0] d);
    cfg_n = c; wr_n = w; rd_n = r; shift_n = s; sdi = b; din = d;
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic do_reset(bit m);
    cfg_n = 1; wr_n = 1; rd_n = 1; shift_n = 1; rst = 1; mode = m;
    @(negedge clk); @(negedge clk);
    cmp("R1");
    rst = 0;
    mode = ~m;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state in parallel mode
    do_reset(1'b0);
    chk("R1", "empty_def", 32'(e_o), 32'h07F);
    chk("R1", "full_def", 32'(f_o), 32'h0FF);
    chk("R1", "vld_clr", 32'(vld), 32'h0);
    // R5 read defaults: 7F, 00, FF, 00
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    chk("R5", "rd0", 32'(dout), 32'h7F);
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    chk("R5", "rd1", 32'(dout), 32'h00);
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    step("R10", 1, 1, 1, 1, 0, 8'h00);
    // R2 R3 parallel write of four slices
    step("R2", 0, 0, 1, 1, 0, 8'hAB);
    step("R3", 0, 0, 1, 1, 0, 8'h5C);
    step("R3", 0, 0, 1, 1, 0, 8'h34);
    step("R3", 0, 0, 1, 1, 0, 8'hF2);
    chk("R3", "empty_par", 32'(e_o), 32'hCAB);
    chk("R3", "full_par", 32'(f_o), 32'h234);
    // R4 fifth write wraps to empty low slice
    step("R4", 0, 0, 1, 1, 0, 8'h66);
    chk("R4", "wrap", 32'(e_o), 32'hC66);
    // R6 read pointer wrapped to slice 0 while write pointer sits at slice 1
    step("R6", 0, 1, 0, 1, 0, 8'h00);
    chk("R6", "rd_e_lo", 32'(dout), 32'h66);
    step("R6", 0, 1, 0, 1, 0, 8'h00);
    chk("R6", "rd_e_hi", 32'(dout), 32'h0C);
    step("R6", 0, 0, 1, 1, 0, 8'h09);
    chk("R6", "wr_e_hi", 32'(e_o), 32'h966);
    step("R6", 0, 1, 0, 1, 0, 8'h00);
    chk("R6", "rd_f_lo", 32'(dout), 32'h34);
    // R9 memory pass-through
    step("R9", 1, 0, 1, 1, 0, 8'hFF);
    chk("R9", "mw", 32'(mw), 32'h1);
    step("R9", 1, 1, 0, 1, 0, 8'hFF);
    chk("R9", "mr", 32'(mr), 32'h1);
    step("R9", 1, 0, 0, 1, 0, 8'hFF);
    step("R9", 1, 1, 1, 1, 0, 8'hFF);
    chk("R9", "none", 32'({mw, mr}), 32'h0);
    chk("R9", "untouched", 32'(e_o), 32'h966);
    // R10 unlisted combinations
    step("R10", 0, 0, 0, 1, 0, 8'h11);
    step("R10", 0, 0, 1, 0, 1, 8'h11);
    step("R10", 0, 1, 0, 0, 1, 8'h11);
    step("R10", 0, 0, 0, 0, 1, 8'h11);
    step("R10", 0, 1, 1, 1, 1, 8'h11);
    chk("R10", "hold_e", 32'(e_o), 32'h966);
    chk("R10", "hold_dout", 32'(dout), 32'h34);
    // R8 shift ignored in parallel mode
    for (int i = 0; i < 4; i++) step("R8", 0, 1, 1, 0, 1, 8'h00);
    chk("R8", "no_shift", 32'(f_o), 32'h234);

    // serial mode
    do_reset(1'b1);
    begin
      logic [23:0] pat;
      pat = {12'h9AE, 12'h135};
      for (int i = 0; i < 24; i++) step("R7", 0, 1, 1, 0, pat[i], 8'h00);
    end
    chk("R7", "ser_empty", 32'(e_o), 32'h135);
    chk("R7", "ser_full", 32'(f_o), 32'h9AE);
    // R8 parallel write ignored in serial mode, mode input toggled after reset
    step("R8", 0, 0, 1, 1, 0, 8'h55);
    chk("R8", "no_pwr", 32'(e_o), 32'h135);
    // R5 read-back allowed in serial mode
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    chk("R5", "ser_rd0", 32'(dout), 32'h35);
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    step("R5", 0, 1, 0, 1, 0, 8'h00);
    chk("R5", "ser_rd3", 32'(dout), 32'h09);
    step("R10", 1, 1, 1, 1, 0, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule